// File: doc/BRIEF.md
# Outbound Address Window Translator

The block maps outbound request addresses from a 32-bit local space into a 36-bit link-side space. It holds a small set of windows, each with a base address, a power-of-two size, a target (translation) address and an enable. Every request is compared against all enabled programmable windows. When a window matches, the bits above the window's size boundary are replaced by that window's target bits, and the offset below the boundary passes through. A request that matches no window falls back to window 0, the default window. Window 0 always counts as enabled and covers the whole local space, so only its upper target bits (35:32) take effect.

Software programs the windows through a word-wide synchronous register port. A translation appears one clock after the request, with a valid flag and the index of the window that was used. A mode input selects root-complex or endpoint operation. Neither mode checks the translated address against any downstream range, so the mode has no effect on translation. Overlapping windows are outside the intended use. When they occur, the lowest-numbered matching programmable window wins.

Register map: the byte offset is `{0, window[2:0], field[1:0], 2'b00}`. The fields are:
- 0: base address.
- 1: target bits 31:0.
- 2: target bits 35:32, held in data[3:0].
- 3: control, with the enable in bit 0 and the size (log2 bytes) in bits 13:8.

Top module: `atu_xlate_top`

## Requirements
- R1: After reset, out_valid is 0. Every programmable window is disabled, and its control reads 0x00000C00 (size 12, enable 0). The default window's target is zero, so a request at address A returns {4'h0, A} with index 0.
- R2: out_valid is 1 in exactly the cycle after a cycle with req_valid high, and 0 otherwise.
- R3: A request inside an enabled window w of size s returns index w. Output bits 35:s come from the window's target and bits s-1:0 come from the request address.
- R4: A request that matches no enabled programmable window returns index 0 and {target0[35:32], address}.
- R5: A disabled window (control bit 0 = 0) never matches, whatever its base and size.
- R6: When several enabled windows match, the one with the lowest index among 1..4 is used.
- R7: A size written below 12 reads back as 12, and a size above 32 reads back as 32. The clamped value is the one used for matching.
- R8: A read (rd_en) returns the addressed register on rd_data in the next cycle. Writes to window 0's base or control, to windows 5..7, to offsets at or above 0x80, or to offsets with bits 1:0 non-zero change nothing. Reads of window 0's control return 0x00002001, its base returns 0, and unmapped words return 0.
- R9: Base bits below a window's size are ignored when matching, and target bits below the size are ignored when translating.
- R10: The value of rc_mode has no effect on out_valid, out_addr or out_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rc_mode | input | 1 | 1 = root-complex, 0 = endpoint; does not alter translation |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_off | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data, valid the cycle after rd_en |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Local request address |
| out_valid | output | 1 | Translated result valid |
| out_addr | output | 36 | Translated link-side address |
| out_idx | output | 3 | Index of the window used |

## Verification
The bench builds the block with its default of five windows, a 32-bit local address and a 36-bit target. This places four programmable windows alongside the default window. With that many windows the bench can set up a three-way overlap to show lowest-index priority, and keep a disabled window that lies over a live address. The 32-bit ceiling on the local address makes a full-span window (size 32) reachable, so the clamp at both ends and the ignored low target bits can be seen at the output.

// File: rtl/atu_pkg.sv
package atu_pkg;
    localparam int LA_W    = 32;
    localparam int XA_W    = 36;
    localparam int XH_W    = XA_W - LA_W;
    localparam int SZ_W    = 6;
    localparam int MIN_SZ  = 12;
    localparam int DATA_W  = 32;
    localparam int OFF_W   = 8;
    localparam int WIN_FLD = 3;

    typedef struct packed {
        logic            en;
        logic [SZ_W-1:0] size;
        logic [LA_W-1:0] base;
        logic [XA_W-1:0] target;
    } win_cfg_t;

    typedef enum logic [1:0] {
        FLD_BASE  = 2'd0,
        FLD_TLO   = 2'd1,
        FLD_THI   = 2'd2,
        FLD_CTRL  = 2'd3
    } fld_e;

    function automatic logic [SZ_W-1:0] clamp_size(input logic [SZ_W-1:0] raw);
        if (raw < SZ_W'(MIN_SZ))
            return SZ_W'(MIN_SZ);
        else if (raw > SZ_W'(LA_W))
            return SZ_W'(LA_W);
        else
            return raw;
    endfunction

    function automatic logic [XA_W-1:0] low_mask(input logic [SZ_W-1:0] sz);
        logic [XA_W-1:0] m;
        for (int i = 0; i < XA_W; i++)
            m[i] = (i < int'(sz));
        return m;
    endfunction
endpackage

// File: rtl/atu_regfile.sv
module atu_regfile
    import atu_pkg::*;
#(
    parameter int NWIN = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [OFF_W-1:0]      reg_off,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data,
    output win_cfg_t [NWIN-1:0]   cfg_o
);
    logic [WIN_FLD-1:0] acc_win;
    fld_e               acc_fld;
    logic               acc_ok;

    assign acc_win = reg_off[6:4];
    assign acc_fld = fld_e'(reg_off[3:2]);
    assign acc_ok  = !reg_off[7] && (reg_off[1:0] == 2'b00);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic            wsel;
        logic [XA_W-1:0] tgt_q;

        assign wsel = wr_en && acc_ok && (acc_win == WIN_FLD'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tgt_q <= '0;
            end else if (wsel && acc_fld == FLD_TLO) begin
                tgt_q[LA_W-1:0] <= wr_data;
            end else if (wsel && acc_fld == FLD_THI) begin
                tgt_q[XA_W-1:LA_W] <= wr_data[XH_W-1:0];
            end
        end

        if (w == 0) begin : g_dflt
            assign cfg_o[w].en     = 1'b1;
            assign cfg_o[w].size   = SZ_W'(LA_W);
            assign cfg_o[w].base   = '0;
            assign cfg_o[w].target = tgt_q;
        end else begin : g_prog
            logic            en_q;
            logic [SZ_W-1:0] size_q;
            logic [LA_W-1:0] base_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q   <= 1'b0;
                    size_q <= SZ_W'(MIN_SZ);
                    base_q <= '0;
                end else if (wsel && acc_fld == FLD_BASE) begin
                    base_q <= wr_data;
                end else if (wsel && acc_fld == FLD_CTRL) begin
                    en_q   <= wr_data[0];
                    size_q <= clamp_size(wr_data[8+SZ_W-1:8]);
                end
            end

            assign cfg_o[w].en     = en_q;
            assign cfg_o[w].size   = size_q;
            assign cfg_o[w].base   = base_q;
            assign cfg_o[w].target = tgt_q;

            AST_SIZE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
                (size_q >= SZ_W'(MIN_SZ)) && (size_q <= SZ_W'(LA_W))); // R7
        end
    end

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (acc_ok && int'(acc_win) < NWIN) begin
            for (int w = 0; w < NWIN; w++) begin
                if (acc_win == WIN_FLD'(w)) begin
                    unique case (acc_fld)
                        FLD_BASE: rd_next = cfg_o[w].base;
                        FLD_TLO:  rd_next = cfg_o[w].target[LA_W-1:0];
                        FLD_THI:  rd_next = DATA_W'(cfg_o[w].target[XA_W-1:LA_W]);
                        FLD_CTRL: rd_next = {{(DATA_W-8-SZ_W){1'b0}}, cfg_o[w].size,
                                             7'b0, cfg_o[w].en};
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end
endmodule

// File: rtl/atu_match.sv
module atu_match
    import atu_pkg::*;
#(
    parameter int NWIN  = 5,
    parameter int IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  win_cfg_t [NWIN-1:0]  cfg_i,
    input  logic [LA_W-1:0]      addr_i,
    output logic [IDX_W-1:0]     idx_o,
    output logic [XA_W-1:0]      xaddr_o
);
    logic [NWIN-1:0] hit;
    logic [NWIN-1:0] grant;
    logic            found;
    win_cfg_t        chosen;
    logic [XA_W-1:0] cmask;

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        logic [XA_W-1:0] m;
        assign m      = low_mask(cfg_i[w].size);
        assign hit[w] = cfg_i[w].en &&
                        (((addr_i ^ cfg_i[w].base) & ~m[LA_W-1:0]) == '0);

        AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
            grant[w] |-> cfg_i[w].en); // R5
    end

    always_comb begin
        grant = '0;
        idx_o = '0;
        found = 1'b0;
        for (int w = 1; w < NWIN; w++) begin
            if (hit[w] && !found) begin
                grant[w] = 1'b1;
                idx_o    = IDX_W'(w);
                found    = 1'b1;
            end
        end
        if (!found && hit[0]) begin
            grant[0] = 1'b1;
            idx_o    = '0;
        end
    end

    assign chosen  = cfg_i[idx_o];
    assign cmask   = low_mask(chosen.size);
    assign xaddr_o = (chosen.target & ~cmask) | ({{XH_W{1'b0}}, addr_i} & cmask);

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_MISS_TO_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[NWIN-1:1] == '0) |-> (idx_o == '0)); // R4
endmodule

// File: rtl/atu_outreg.sv
module atu_outreg
    import atu_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LA_W-1:0]   req_addr,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [XA_W-1:0]   xaddr_i,
    output logic              out_valid,
    output logic [XA_W-1:0]   out_addr,
    output logic [IDX_W-1:0]  out_idx
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_idx   <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_addr <= xaddr_i;
                out_idx  <= idx_i;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R2
    AST_MIN_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_addr[MIN_SZ-1:0] == $past(req_addr[MIN_SZ-1:0]))); // R3
endmodule

// File: rtl/atu_xlate_top.sv
module atu_xlate_top
    import atu_pkg::*;
#(
    parameter int NWIN  = 5,
    parameter int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rc_mode,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [OFF_W-1:0]   reg_off,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               req_valid,
    input  logic [LA_W-1:0]    req_addr,
    output logic               out_valid,
    output logic [XA_W-1:0]    out_addr,
    output logic [IDX_W-1:0]   out_idx
);
    win_cfg_t [NWIN-1:0] cfg;
    logic [IDX_W-1:0]    m_idx;
    logic [XA_W-1:0]     m_xaddr;

    atu_regfile #(.NWIN(NWIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_off(reg_off), .wr_data(wr_data), .rd_data(rd_data), .cfg_o(cfg)
    );

    atu_match #(.NWIN(NWIN), .IDX_W(IDX_W)) u_match (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .addr_i(req_addr),
        .idx_o(m_idx), .xaddr_o(m_xaddr)
    );

    atu_outreg #(.IDX_W(IDX_W)) u_out (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .idx_i(m_idx), .xaddr_i(m_xaddr),
        .out_valid(out_valid), .out_addr(out_addr), .out_idx(out_idx)
    );

    AST_MODE_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rc_mode) |=> out_valid); // R10
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_idx) < NWIN)); // R3
endmodule

// File: tb/sim_atu_xlate_top.sv
module sim_atu_xlate_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rc_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  reg_off = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        out_valid;
    logic [35:0] out_addr;
    logic [2:0]  out_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atu_xlate_top u0 (
        .clk(clk), .rst_n(rst_n), .rc_mode(rc_mode), .wr_en(wr_en), .rd_en(rd_en),
        .reg_off(reg_off), .wr_data(wr_data), .rd_data(rd_data),
        .req_valid(req_valid), .req_addr(req_addr),
        .out_valid(out_valid), .out_addr(out_addr), .out_idx(out_idx)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_off = off; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; reg_off = off;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, {4'h0, rd_data}, {4'h0, exp});
    endtask

    task automatic xl(input logic [31:0] a, input logic m, input logic [35:0] ea,
                      input logic [2:0] ei, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; rc_mode = m;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, {35'b0, out_valid}, 36'd1);
        chk({tag, " addr"}, out_addr, ea);
        chk({tag, " idx"}, {33'b0, out_idx}, {33'b0, ei});
    endtask

    task automatic t_reset;
        chk("R1 out_valid after reset", {35'b0, out_valid}, 36'd0);
        rd(8'h1C, 32'h0000_0C00, "R1 win1 ctrl reset");
        rd(8'h04, 32'h0, "R1 default target reset");
        xl(32'h1234_5678, 1'b0, 36'h0_1234_5678, 3'd0, "R1 request after reset");
    endtask

    task automatic t_latency;
        xl(32'h0000_0ABC, 1'b0, 36'h0_0000_0ABC, 3'd0, "R2 single");
        @(negedge clk);
        chk("R2 valid drops", {35'b0, out_valid}, 36'd0);
    endtask

    task automatic t_default;
        wr(8'h08, 32'h9);
        xl(32'hDEAD_BEEF, 1'b0, 36'h9_DEAD_BEEF, 3'd0, "R4 miss uses default");
    endtask

    task automatic t_hit;
        wr(8'h10, 32'h4000_0000);
        wr(8'h14, 32'h1200_0000);
        wr(8'h18, 32'hA);
        wr(8'h1C, 32'h0000_1801);
        xl(32'h40AB_CDEF, 1'b0, 36'hA_12AB_CDEF, 3'd1, "R3 hit win1");
        xl(32'h4100_0000, 1'b0, 36'h9_4100_0000, 3'd0, "R4 just above win1");
    endtask

    task automatic t_disabled;
        wr(8'h20, 32'h8000_0000);
        wr(8'h24, 32'h0);
        wr(8'h28, 32'h3);
        wr(8'h2C, 32'h0000_1000);
        xl(32'h8000_1234, 1'b0, 36'h9_8000_1234, 3'd0, "R5 disabled win2");
        wr(8'h2C, 32'h0000_1001);
        xl(32'h8000_1234, 1'b0, 36'h3_0000_1234, 3'd2, "R3 enabled win2");
    endtask

    task automatic t_overlap;
        wr(8'h30, 32'h4000_0000);
        wr(8'h34, 32'h5555_5000);
        wr(8'h38, 32'h5);
        wr(8'h3C, 32'h0000_0C01);
        xl(32'h4000_0123, 1'b0, 36'hA_1200_0123, 3'd1, "R6 overlap lowest wins");
        wr(8'h1C, 32'h0000_1800);
        xl(32'h4000_0123, 1'b0, 36'h5_5555_5123, 3'd3, "R6 win3 after win1 off");
        xl(32'h4000_1123, 1'b0, 36'h9_4000_1123, 3'd0, "R3 outside 4KB win3");
    endtask

    task automatic t_clamp;
        wr(8'h40, 32'h1234_5678);
        wr(8'h44, 32'h1111_1111);
        wr(8'h48, 32'h7);
        wr(8'h4C, 32'h0000_0501);
        rd(8'h4C, 32'h0000_0C01, "R7 clamp low");
        wr(8'h4C, 32'h0000_2801);
        rd(8'h4C, 32'h0000_2001, "R7 clamp high");
        xl(32'hF000_0000, 1'b0, 36'h7_F000_0000, 3'd4, "R7 full span win4");
        xl(32'h8000_1234, 1'b0, 36'h3_0000_1234, 3'd2, "R6 win2 over win4");
        wr(8'h4C, 32'h0000_2000);
    endtask

    task automatic t_align;
        wr(8'h20, 32'h8000_0FFF);
        wr(8'h24, 32'h0000_FFFF);
        xl(32'h8000_ABCD, 1'b0, 36'h3_0000_ABCD, 3'd2, "R9 low bits ignored");
    endtask

    task automatic t_mode;
        xl(32'h8000_ABCD, 1'b1, 36'h3_0000_ABCD, 3'd2, "R10 rc mode hit");
        xl(32'hDEAD_BEEF, 1'b1, 36'h9_DEAD_BEEF, 3'd0, "R10 rc mode miss");
    endtask

    task automatic t_regs;
        rd(8'h18, 32'hA, "R8 target hi readback");
        wr(8'h19, 32'hF);
        rd(8'h18, 32'hA, "R8 unaligned write ignored");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R8 default base fixed");
        wr(8'h0C, 32'h0);
        rd(8'h0C, 32'h0000_2001, "R8 default ctrl fixed");
        wr(8'h54, 32'h5A5A_5A5A);
        rd(8'h54, 32'h0, "R8 unmapped window");
        wr(8'h94, 32'h5A5A_5A5A);
        rd(8'h14, 32'h1200_0000, "R8 high offset write ignored");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_latency;
        t_default;
        t_hit;
        t_disabled;
        t_overlap;
        t_clamp;
        t_align;
        t_mode;
        t_regs;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule